// File: doc/BRIEF.md
# Processor Reset Vector Sequencer

This block walks an 8-bit processor with a 16-bit address space from reset to its first opcode fetch. When reset is released it runs a fixed series of bus cycles, and every one of them is a read. A short run of dummy cycles comes first. These repeat the address that was on the bus while reset was held.

Three stack accesses follow. Each one goes to page 1 at the current stack pointer, and the stack pointer steps down by one after each access. Nothing is written to memory. An interrupt-style push therefore becomes a silent sequence.

The sequencer then reads the start vector, low byte at 0xFFFC and high byte at 0xFFFD. It sets the interrupt-disable and break bits of the status register. It loads the program counter and raises a one-clock done pulse so that opcode fetch can take over.

Each bus cycle takes one clock enable. The address is presented combinationally from the current phase, and read data is sampled at the clock edge where the enable is high. The reset is synchronous and active low. While reset is low, the stack pointer, the status register and the held address are taken from the inputs. Asserting reset at any time restarts the sequence.

Top module: `rvs_seq`

## Requirements
- R1: The read strobe `bus_rd` is 1 in every cycle, before, during and after the sequence (1 = read).
- R2: While reset is low, and in the cycle after its release, `bus_addr` equals `cur_addr` as sampled during reset. In that state `sp_out` equals `sp_init`, `stat_out` equals `stat_init`, `pc_out` is 0 and `done` is 0.
- R3: The first DUMMY_CNT (default 2) enabled bus cycles drive the held address and leave `sp_out` unchanged.
- R4: The next STACK_CNT (default 3) enabled cycles drive {0x01, sp_out}. `sp_out` falls by one at the end of each of them, so 0xC0 gives 0x01C0, 0x01BF, 0x01BE and ends at 0xBD.
- R5: After the stack cycles, the next enabled cycle addresses 0xFFFC and the one after it addresses 0xFFFD.
- R6: At the end of the 0xFFFC cycle, status bit 2 becomes 1. At the end of the 0xFFFD cycle, bit 4 also becomes 1. No other status bit changes (0x02 gives 0x06, then 0x16).
- R7: In the clock after the 0xFFFD cycle's enable, `done` is 1 for exactly one clock, and `pc_out` and `bus_addr` both equal {byte read at 0xFFFD, byte read at 0xFFFC}.
- R8: In a clock with `cyc_en` low, `bus_addr`, `sp_out`, `stat_out` and `pc_out` hold their values.
- R9: Asserting reset in the middle of the sequence restarts it from the first dummy cycle, with `sp_init`, `stat_init` and `cur_addr` sampled again.
- R10: Once the sequence has completed, further enables change none of `bus_addr`, `sp_out`, `stat_out` or `pc_out`, and `done` stays 0.
- R11: The stack pointer wraps modulo 256. A start of 0x01 gives addresses 0x0101, 0x0100, 0x01FF and ends at 0xFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; restarts the sequence |
| cyc_en | input | 1 | One bus cycle completes at each clock where this is 1 |
| rd_data | input | 8 | Read data, sampled at the end of an enabled cycle |
| sp_init | input | 8 | Stack pointer value loaded during reset |
| stat_init | input | 8 | Status register value loaded during reset |
| cur_addr | input | 16 | Address held on the bus by the dummy cycles, sampled during reset |
| bus_addr | output | 16 | Address for the current bus cycle |
| bus_rd | output | 1 | Read strobe, 1 = read |
| sp_out | output | 8 | Current stack pointer |
| stat_out | output | 8 | Current status register |
| pc_out | output | 16 | Program counter loaded from the vector |
| done | output | 1 | One-clock pulse when the program counter has been loaded |

## Verification
The assertions take for granted that no state moves except at an enabled clock, and that the only status change is bits being set. Their precondition is that the register state last came from reset and not from outside values. They also assume `cyc_en` is a clean level at the clock edge; the bench meets this by changing inputs only well away from the rising edge. The stimulus keeps `cur_addr`, `sp_init` and `stat_init` changing only while reset is low, because the block samples them only at that time. Stall clocks between enables, a mid-sequence reset and a stack pointer near zero are all driven this way.

// File: rtl/rvs_pkg.sv
// Shared types for the reset vector sequencer.
// Assumes: nothing beyond the standard types.
package rvs_pkg;
    typedef enum logic [2:0] {
        PH_DUMMY = 3'd0,
        PH_STACK = 3'd1,
        PH_VLO   = 3'd2,
        PH_VHI   = 3'd3,
        PH_RUN   = 3'd4
    } rvs_phase_t;
endpackage

// File: rtl/rvs_ctrl.sv
// Phase controller: decides which bus cycle of the reset sequence is current
// and advances on each clock enable.
// Assumes: DUMMY_CNT >= 1 and STACK_CNT >= 1; synchronous active-low reset.
module rvs_ctrl
    import rvs_pkg::*;
#(
    parameter int DUMMY_CNT = 2,
    parameter int STACK_CNT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_en,
    output rvs_phase_t phase,
    output logic       step_stack,
    output logic       step_vlo,
    output logic       step_vhi
);
    localparam int MAXC  = (DUMMY_CNT > STACK_CNT) ? DUMMY_CNT : STACK_CNT;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CNT_W-1:0] LAST_D = CNT_W'(DUMMY_CNT - 1);
    localparam logic [CNT_W-1:0] LAST_S = CNT_W'(STACK_CNT - 1);

    logic [CNT_W-1:0] cnt;

    // Strobes telling the register unit which cycle completes this clock.
    always_comb begin
        step_stack = cyc_en && (phase == PH_STACK);
        step_vlo   = cyc_en && (phase == PH_VLO);
        step_vhi   = cyc_en && (phase == PH_VHI);
    end

    // Phase and in-phase cycle counter, advanced by the clock enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_DUMMY;
            cnt   <= '0;
        end else if (cyc_en) begin
            unique case (phase)
                PH_DUMMY: begin
                    if (cnt == LAST_D) begin
                        phase <= PH_STACK;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_STACK: begin
                    if (cnt == LAST_S) begin
                        phase <= PH_VLO;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_VLO:  phase <= PH_VHI;
                PH_VHI:  phase <= PH_RUN;
                default: phase <= PH_RUN;
            endcase
        end
    end
endmodule

// File: rtl/rvs_regs.sv
// Register unit: holds the stack pointer, status, held address, vector low
// byte and program counter, and produces the done pulse.
// Assumes: the step strobes are one-hot and qualified by the clock enable.
module rvs_regs #(
    parameter int         STAT_W   = 8,
    parameter int         IDIS_BIT = 2,
    parameter int         BRK_BIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_stack,
    input  logic              step_vlo,
    input  logic              step_vhi,
    input  logic [7:0]        rd_data,
    input  logic [7:0]        sp_init,
    input  logic [STAT_W-1:0] stat_init,
    input  logic [15:0]       cur_addr,
    output logic [7:0]        sp,
    output logic [STAT_W-1:0] stat,
    output logic [15:0]       hold_addr,
    output logic [15:0]       pc,
    output logic              done
);
    localparam logic [STAT_W-1:0] IDIS_MASK = STAT_W'(1) << IDIS_BIT;
    localparam logic [STAT_W-1:0] BRK_MASK  = STAT_W'(1) << BRK_BIT;

    logic [7:0] vec_lo;

    // Stack pointer: loaded in reset, stepped down by each stack cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          sp <= sp_init;
        else if (step_stack) sp <= sp - 8'd1;
    end

    // Status: loaded in reset, bits set at the two vector cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)        stat <= stat_init;
        else if (step_vlo) stat <= stat | IDIS_MASK;
        else if (step_vhi) stat <= stat | BRK_MASK;
    end

    // Address repeated by the dummy cycles, captured while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_addr <= cur_addr;
    end

    // Vector capture, program counter load and one-clock done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_lo <= '0;
            pc     <= '0;
            done   <= 1'b0;
        end else begin
            done <= step_vhi;
            if (step_vlo) vec_lo <= rd_data;
            if (step_vhi) pc     <= {rd_data, vec_lo};
        end
    end
endmodule

// File: rtl/rvs_addr.sv
// Address selector: forms the bus address for the current phase.
// Assumes: the phase is stable during a clock; purely combinational.
module rvs_addr
    import rvs_pkg::*;
#(
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [15:0] VEC_ADDR   = 16'hFFFC
) (
    input  rvs_phase_t  phase,
    input  logic [15:0] hold_addr,
    input  logic [7:0]  sp,
    input  logic [15:0] pc,
    output logic [15:0] addr
);
    // Select the address of the bus cycle in progress.
    always_comb begin
        unique case (phase)
            PH_DUMMY: addr = hold_addr;
            PH_STACK: addr = {STACK_PAGE, sp};
            PH_VLO:   addr = VEC_ADDR;
            PH_VHI:   addr = VEC_ADDR + 16'd1;
            default:  addr = pc;
        endcase
    end
endmodule

// File: rtl/rvs_seq.sv
// Reset vector sequencer top: after reset it runs dummy reads, read-only
// stack cycles and a two-byte vector fetch, then loads the program counter.
// Assumes: one bus cycle per clock enable; synchronous active-low reset.
module rvs_seq
    import rvs_pkg::*;
#(
    parameter int          DUMMY_CNT  = 2,
    parameter int          STACK_CNT  = 3,
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [15:0] VEC_ADDR   = 16'hFFFC
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cyc_en,
    input  logic [7:0]  rd_data,
    input  logic [7:0]  sp_init,
    input  logic [7:0]  stat_init,
    input  logic [15:0] cur_addr,
    output logic [15:0] bus_addr,
    output logic        bus_rd,
    output logic [7:0]  sp_out,
    output logic [7:0]  stat_out,
    output logic [15:0] pc_out,
    output logic        done
);
    rvs_phase_t  phase;
    logic        step_stack, step_vlo, step_vhi;
    logic [15:0] hold_addr;

    // Every cycle of this sequence is a read.
    assign bus_rd = 1'b1;

    rvs_ctrl #(
        .DUMMY_CNT (DUMMY_CNT),
        .STACK_CNT (STACK_CNT)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_en     (cyc_en),
        .phase      (phase),
        .step_stack (step_stack),
        .step_vlo   (step_vlo),
        .step_vhi   (step_vhi)
    );

    rvs_regs #(
        .STAT_W   (8),
        .IDIS_BIT (2),
        .BRK_BIT  (4)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_stack (step_stack),
        .step_vlo   (step_vlo),
        .step_vhi   (step_vhi),
        .rd_data    (rd_data),
        .sp_init    (sp_init),
        .stat_init  (stat_init),
        .cur_addr   (cur_addr),
        .sp         (sp_out),
        .stat       (stat_out),
        .hold_addr  (hold_addr),
        .pc         (pc_out),
        .done       (done)
    );

    rvs_addr #(
        .STACK_PAGE (STACK_PAGE),
        .VEC_ADDR   (VEC_ADDR)
    ) u_addr (
        .phase     (phase),
        .hold_addr (hold_addr),
        .sp        (sp_out),
        .pc        (pc_out),
        .addr      (bus_addr)
    );
endmodule

// File: rtl/rvs_seq_chk.sv
// Checker for the reset vector sequencer, bound to the top module.
// Assumes: ports observed at the clock; reset synchronous and active low.
module rvs_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cyc_en,
    input logic [15:0] bus_addr,
    input logic [7:0]  sp_out,
    input logic [7:0]  stat_out,
    input logic [15:0] pc_out,
    input logic        done
);
    // R4 / R11: the stack pointer only ever moves down by one, modulo 256.
    assert_sp_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (sp_out != $past(sp_out))) |-> (sp_out == $past(sp_out) - 8'd1));

    // R8: nothing visible moves in a clock without an enable.
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cyc_en)) |->
            ($stable(bus_addr) && $stable(sp_out) && $stable(stat_out) && $stable(pc_out)));

    // R7: done lasts one clock.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: at done the bus points at the loaded program counter.
    assert_done_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_addr == pc_out));

    // R6: status bits are never cleared, and only bits 2 and 4 may be set.
    assert_stat_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
            ((($past(stat_out) & ~stat_out) == 8'h00) &&
             ((stat_out & ~$past(stat_out) & 8'hEB) == 8'h00)));
endmodule

bind rvs_seq rvs_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_en   (cyc_en),
    .bus_addr (bus_addr),
    .sp_out   (sp_out),
    .stat_out (stat_out),
    .pc_out   (pc_out),
    .done     (done)
);

// File: tb/tb_rvs_seq.sv
`timescale 1ns/1ps
module tb_rvs_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_en = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic [7:0]  sp_init = 8'h00;
    logic [7:0]  stat_init = 8'h00;
    logic [15:0] cur_addr = 16'h0000;
    logic [15:0] bus_addr;
    logic        bus_rd;
    logic [7:0]  sp_out;
    logic [7:0]  stat_out;
    logic [15:0] pc_out;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rvs_seq dut (
        .clk (clk), .rst_n (rst_n), .cyc_en (cyc_en), .rd_data (rd_data),
        .sp_init (sp_init), .stat_init (stat_init), .cur_addr (cur_addr),
        .bus_addr (bus_addr), .bus_rd (bus_rd), .sp_out (sp_out),
        .stat_out (stat_out), .pc_out (pc_out), .done (done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Hold reset with new inputs, release it and check the reset state (R2).
    task automatic do_reset(input logic [7:0] sp0, input logic [7:0] st0, input logic [15:0] a0);
        @(negedge clk);
        rst_n = 1'b0; cyc_en = 1'b0;
        sp_init = sp0; stat_init = st0; cur_addr = a0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(bus_addr == a0, "R2 addr in reset", 32'(bus_addr), 32'(a0));
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(bus_addr == a0, "R2 addr", 32'(bus_addr), 32'(a0));
        chk(sp_out == sp0, "R2 sp", 32'(sp_out), 32'(sp0));
        chk(stat_out == st0, "R2 stat", 32'(stat_out), 32'(st0));
        chk(pc_out == 16'h0 && !done, "R2 pc/done", {15'h0, done, pc_out}, 32'h0);
    endtask

    // One enabled bus cycle with read data d; checks the strobe (R1).
    task automatic run_cycle(input logic [7:0] d);
        chk(bus_rd == 1'b1, "R1 read strobe", 32'(bus_rd), 32'h1);
        cyc_en = 1'b1; rd_data = d;
        @(posedge clk); #1;
        cyc_en = 1'b0;
    endtask

    // Complete sequence with per-cycle checks (R3..R7, R11 via sp0).
    task automatic full_seq(input logic [7:0] sp0, input logic [7:0] st0, input logic [15:0] a0,
                            input logic [7:0] lo, input logic [7:0] hi, input int stall);
        logic [15:0] pcx;
        pcx = {hi, lo};
        do_reset(sp0, st0, a0);
        for (int i = 0; i < 2; i++) begin
            chk(bus_addr == a0, "R3 dummy addr", 32'(bus_addr), 32'(a0));
            run_cycle(8'h5A);
            chk(sp_out == sp0, "R3 sp kept", 32'(sp_out), 32'(sp0));
            if (stall > 0) begin
                repeat (stall) @(posedge clk); #1;
                chk(sp_out == sp0 && stat_out == st0, "R8 stall dummy",
                    {16'h0, sp_out, stat_out}, {16'h0, sp0, st0});
            end
        end
        for (int i = 0; i < 3; i++) begin
            logic [7:0] s;
            s = sp0 - 8'(i);
            chk(bus_addr == {8'h01, s}, "R4/R11 stack addr", 32'(bus_addr), 32'({8'h01, s}));
            run_cycle(8'hA5);
            chk(sp_out == s - 8'd1, "R4/R11 sp step", 32'(sp_out), 32'(s - 8'd1));
            if (stall > 0) begin
                repeat (stall) @(posedge clk); #1;
                chk(bus_addr == {8'h01, s - 8'd1} || i == 2, "R8 stall stack addr",
                    32'(bus_addr), 32'({8'h01, s - 8'd1}));
                chk(sp_out == s - 8'd1, "R8 stall sp", 32'(sp_out), 32'(s - 8'd1));
            end
        end
        chk(bus_addr == 16'hFFFC, "R5 vector low addr", 32'(bus_addr), 32'hFFFC);
        chk(stat_out == st0, "R6 stat before", 32'(stat_out), 32'(st0));
        run_cycle(lo);
        chk(stat_out == (st0 | 8'h04), "R6 idis set", 32'(stat_out), 32'(st0 | 8'h04));
        chk(bus_addr == 16'hFFFD, "R5 vector high addr", 32'(bus_addr), 32'hFFFD);
        chk(!done, "R7 no early done", 32'(done), 32'h0);
        if (stall > 0) begin
            repeat (stall) @(posedge clk); #1;
            chk(bus_addr == 16'hFFFD && pc_out == 16'h0, "R8 stall vector",
                {bus_addr, pc_out}, {16'hFFFD, 16'h0});
        end
        run_cycle(hi);
        chk(done == 1'b1, "R7 done high", 32'(done), 32'h1);
        chk(pc_out == pcx, "R7 pc loaded", 32'(pc_out), 32'(pcx));
        chk(bus_addr == pcx, "R7 addr=pc", 32'(bus_addr), 32'(pcx));
        chk(stat_out == (st0 | 8'h14), "R6 brk set", 32'(stat_out), 32'(st0 | 8'h14));
        chk(sp_out == sp0 - 8'd3, "R4 sp final", 32'(sp_out), 32'(sp0 - 8'd3));
        @(posedge clk); #1;
        chk(done == 1'b0, "R7 done one clock", 32'(done), 32'h0);
    endtask

    task automatic t_basic();
        full_seq(8'hC0, 8'h02, 16'h00FF, 8'h34, 8'h12, 0);
    endtask

    task automatic t_wrap();
        full_seq(8'h01, 8'h00, 16'h1234, 8'hCD, 8'hAB, 0);
        chk(sp_out == 8'hFE, "R11 wrapped sp", 32'(sp_out), 32'hFE);
    endtask

    task automatic t_stall();
        full_seq(8'hFF, 8'h41, 16'h0150, 8'h00, 8'h80, 3);
    endtask

    task automatic t_restart();
        do_reset(8'h80, 8'h00, 16'h2222);
        run_cycle(8'h00); run_cycle(8'h00); run_cycle(8'h00);
        chk(sp_out == 8'h7F, "R9 midway sp", 32'(sp_out), 32'h7F);
        run_cycle(8'h00); run_cycle(8'h00); run_cycle(8'h99);
        chk(stat_out == 8'h04, "R9 midway stat", 32'(stat_out), 32'h04);
        full_seq(8'h40, 8'h20, 16'h3333, 8'h78, 8'h56, 0);
        chk(pc_out == 16'h5678, "R9 restart result", 32'(pc_out), 32'h5678);
    endtask

    task automatic t_after_done();
        full_seq(8'hC0, 8'h02, 16'h00FF, 8'hEF, 8'hBE, 0);
        for (int i = 0; i < 3; i++) begin
            run_cycle(8'h11);
            chk(!done, "R10 no done", 32'(done), 32'h0);
            chk(bus_addr == 16'hBEEF && pc_out == 16'hBEEF, "R10 pc/addr",
                {bus_addr, pc_out}, 32'hBEEFBEEF);
            chk(sp_out == 8'hBD && stat_out == 8'h16, "R10 sp/stat",
                {16'h0, sp_out, stat_out}, 32'h0000BD16);
        end
    endtask

    initial begin
        t_basic();
        t_wrap();
        t_stall();
        t_restart();
        t_after_done();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule